// File: doc/BRIEF.md
# Inbound PCI Memory-Read Prefetch Target

This block is the target side of a PCI bridge that answers memory reads issued by some other bus master. It watches each address phase. When the command is a memory read and the address falls inside a configured window, it claims the transaction. It then streams consecutive doublewords from a simple memory read port into a pooled prefetch store and returns them on the 32-bit AD lines, asserting target-ready whenever a word is waiting at the head of the store.

The store has two stages. A memory-facing queue of 10 entries feeds a bus-facing queue of 16 entries, so up to 26 doublewords can be buffered or in flight. Fetching runs ahead of the master until that capacity is used. It resumes as soon as the master takes a word. Reads wait while an inbound posted write is still draining to memory. A burst that reaches the last doubleword of a memory page is cut there, and that page end is also a 32-byte line end. Every buffered or late-arriving word is discarded when the transaction ends.

Bus controls are active-low and split into separate inputs and outputs, with output-enable flags in place of tristate pins. The memory side is a request channel with valid/ready and an in-order response channel that is always accepted.

Top module: `pci_rd_prefetch`

## Requirements
- R1: An address phase is a clock where `frame_n` is low, it was high on the previous clock, and `irdy_n` is high. If `cbe_n` equals 4'b0110 (memory read) and `ad_in` lies in [WIN_BASE, WIN_BASE+WIN_SIZE), the block drives `devsel_n` low from the next clock until the transaction ends.
- R2: An address outside the window leaves `devsel_n`, `trdy_n` and `stop_n` high and issues no memory request.
- R3: Any command code other than 4'b0110 is ignored, even when the address is in the window.
- R4: The sum of buffered words and outstanding memory requests never exceeds 26. With the master holding `irdy_n` high and the page allowing it, exactly 26 requests are issued.
- R5: Every doubleword the master takes frees one slot, and fetching continues until the burst ends or the page end is reached.
- R6: Requests start at the master's dword address and step by 4 bytes. The words returned on `ad_out` are the memory contents of consecutive addresses, in order.
- R7: `trdy_n` is low only while a fetched word is at the head of the bus-facing queue. That word is on `ad_out` with `ad_oe` high. In the first clock after a claim, `trdy_n` is high.
- R8: When a transaction ends, all buffered words and any responses still pending are discarded. The next read returns only its own data.
- R9: The target drives `stop_n` low together with `trdy_n` exactly on the doubleword at page offset PAGE_BYTES-4 (default page 4096 bytes). The transaction ends on that transfer, and no request is issued beyond that page.
- R10: While `wr_empty` is low, no memory request is issued.
- R11: While `frame_n` is high in a claimed transaction, a request is issued only when nothing is buffered or outstanding, which is the single word the final phase needs.
- R12: A word transfers only on a clock with both `irdy_n` and `trdy_n` low. A transfer with `frame_n` high ends the transaction, and `devsel_n` goes high on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Master cycle framing, active low |
| irdy_n | input | 1 | Master ready, active low |
| ad_in | input | 32 | Address/data from the bus |
| cbe_n | input | 4 | Command in the address phase, byte enables afterwards |
| wr_empty | input | 1 | High when no inbound posted write is pending |
| devsel_n | output | 1 | Claim indication, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Disconnect request, active low |
| tgt_oe | output | 1 | Enables the target control outputs |
| ad_out | output | 32 | Read data toward the bus |
| ad_oe | output | 1 | Enables `ad_out` onto the bus |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the requested doubleword |
| mem_rsp_valid | input | 1 | Read data returned, in request order |
| mem_rsp_data | input | 32 | Returned doubleword |

## Verification
The bench aims at the capacity edge first. It stalls the master until the store is full and expects exactly 26 requests, so an off-by-one credit check would show up as 25 or 27. It ends a burst while requests are still in flight and then reads a new address, so a design that let late responses into the fresh buffer would return stale words. Bursts that start a few words below a page end must stop on the last word of the page. A design that decoded the page end wrongly would either disconnect early or send a request into the next page. The bench also checks that no request goes out while posted writes are pending, or while the final phase is signalled with data already buffered.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    localparam logic [3:0] CMD_MEM_READ = 4'b0110;

    typedef enum logic {
        TGT_IDLE = 1'b0,
        TGT_BUSY = 1'b1
    } tgt_state_e;

    // Result of decoding one address phase
    typedef struct packed {
        logic        hit;
        logic [29:0] dw;
    } claim_t;

    function automatic logic addr_in_window(input logic [31:0] a,
                                            input logic [31:0] base,
                                            input logic [31:0] size);
        logic [31:0] off;
        off = a - base;
        return off < size;
    endfunction

    function automatic logic is_page_last(input logic [29:0] dw,
                                          input int unsigned page_dw);
        logic [29:0] mask;
        mask = 30'(page_dw - 1);
        return (dw & mask) == mask;
    endfunction

endpackage

// File: rtl/pfx_fifo.sv
module pfx_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         push,
    input  logic [WIDTH-1:0]             din,
    input  logic                         pop,
    output logic [WIDTH-1:0]             dout,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] store [DEPTH];
    logic [PW-1:0]    rd_ptr, wr_ptr;
    logic             wr_en, rd_en;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign wr_en = push && !full;
    assign rd_en = pop && !empty;
    assign dout  = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= step(wr_ptr);
            if (rd_en) rd_ptr <= step(rd_ptr);
            count <= count + CW'(wr_en) - CW'(rd_en);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !flush) store[wr_ptr] <= din;
    end

    // R4: the credit scheme upstream must never push into a full queue
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R6: words leave only when present, keeping order intact
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/pfx_decode.sv
module pfx_decode
    import pfx_pkg::*;
#(
    parameter logic [31:0] WIN_BASE = 32'h0010_0000,
    parameter logic [31:0] WIN_SIZE = 32'h0010_0000
) (
    input  logic        idle,
    input  logic        frame_n,
    input  logic        frame_q,
    input  logic        irdy_n,
    input  logic [31:0] ad_in,
    input  logic [3:0]  cbe_n,
    output claim_t      claim
);
    logic addr_phase;

    // Falling FRAME# on an idle bus marks the address phase
    assign addr_phase = idle && !frame_n && frame_q && irdy_n;

    always_comb begin
        claim.hit = addr_phase && (cbe_n == CMD_MEM_READ)
                    && addr_in_window(ad_in, WIN_BASE, WIN_SIZE);
        claim.dw  = ad_in[31:2];
    end

endmodule

// File: rtl/pfx_fetch.sv
module pfx_fetch
    import pfx_pkg::*;
#(
    parameter int CAP     = 26,
    parameter int PAGE_DW = 1024,
    parameter int CW      = $clog2(CAP + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [29:0]   start_dw,
    input  logic          run,
    input  logic          frame_n,
    input  logic          wr_empty,
    input  logic [CW-1:0] occ,
    input  logic          flush,
    input  logic          req_ready,
    input  logic          rsp_valid,
    output logic          req_valid,
    output logic [31:0]   req_addr,
    output logic          rsp_keep
);
    logic [29:0]   fetch_dw;
    logic          fetch_done;
    logic [CW-1:0] pend, disc, pend_nx;
    logic [CW:0]   total;
    logic          room, demand_ok, issue, rsp_drop;

    assign total     = {1'b0, occ} + {1'b0, pend};
    assign room      = total < (CW+1)'(CAP);
    // after the final phase is signalled only the one missing word is fetched
    assign demand_ok = !frame_n || (total == '0);
    assign req_valid = run && !flush && wr_empty && !fetch_done
                       && (disc == '0) && room && demand_ok;
    assign req_addr  = {fetch_dw, 2'b00};
    assign issue     = req_valid && req_ready;
    assign rsp_drop  = rsp_valid && (disc != '0);
    assign rsp_keep  = rsp_valid && (disc == '0);
    assign pend_nx   = pend + CW'(issue) - CW'(rsp_valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_dw   <= '0;
            fetch_done <= 1'b1;
            pend       <= '0;
            disc       <= '0;
        end else begin
            pend <= pend_nx;
            // everything still in flight at the end of a burst is stale
            disc <= flush ? pend_nx : disc - CW'(rsp_drop);
            if (start) begin
                fetch_dw   <= start_dw;
                fetch_done <= 1'b0;
            end else if (flush) begin
                fetch_done <= 1'b1;
            end else if (issue) begin
                fetch_dw <= fetch_dw + 30'd1;
                if (is_page_last(fetch_dw, PAGE_DW)) fetch_done <= 1'b1;
            end
        end
    end

    // R4: buffered plus outstanding words stay within the pooled capacity
    p_capacity_r4: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, occ} + {1'b0, pend}) <= (CW+1)'(CAP));
    // R10: no read may overtake a pending posted write
    p_write_gate_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> wr_empty);

endmodule

// File: rtl/pci_rd_prefetch.sv
module pci_rd_prefetch
    import pfx_pkg::*;
#(
    parameter logic [31:0] WIN_BASE   = 32'h0010_0000,
    parameter logic [31:0] WIN_SIZE   = 32'h0010_0000,
    parameter int          PAGE_BYTES = 4096,
    parameter int          BUS_DEPTH  = 16,
    parameter int          MEM_DEPTH  = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_n,
    input  logic        irdy_n,
    input  logic [31:0] ad_in,
    input  logic [3:0]  cbe_n,
    input  logic        wr_empty,
    output logic        devsel_n,
    output logic        trdy_n,
    output logic        stop_n,
    output logic        tgt_oe,
    output logic [31:0] ad_out,
    output logic        ad_oe,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data
);
    localparam int PAGE_DW = PAGE_BYTES / 4;
    localparam int CAP     = BUS_DEPTH + MEM_DEPTH;
    localparam int CW      = $clog2(CAP + 1);
    localparam int BCW     = $clog2(BUS_DEPTH + 1);
    localparam int MCW     = $clog2(MEM_DEPTH + 1);

    tgt_state_e  state;
    logic        frame_q;
    logic [29:0] out_dw;
    claim_t      claim;
    logic        busy;

    logic [31:0]    mem_dout, bus_dout;
    logic           mem_empty, mem_full, bus_empty, bus_full;
    logic [MCW-1:0] mem_cnt;
    logic [BCW-1:0] bus_cnt;
    logic [CW-1:0]  occ;
    logic           rsp_keep, mv, trdy_act, stop_act, page_end, xfer, tx_end;

    assign busy = (state == TGT_BUSY);

    pfx_decode #(
        .WIN_BASE (WIN_BASE),
        .WIN_SIZE (WIN_SIZE)
    ) u_dec (
        .idle    (!busy),
        .frame_n (frame_n),
        .frame_q (frame_q),
        .irdy_n  (irdy_n),
        .ad_in   (ad_in),
        .cbe_n   (cbe_n),
        .claim   (claim)
    );

    pfx_fetch #(
        .CAP     (CAP),
        .PAGE_DW (PAGE_DW),
        .CW      (CW)
    ) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .start     (claim.hit),
        .start_dw  (claim.dw),
        .run       (busy),
        .frame_n   (frame_n),
        .wr_empty  (wr_empty),
        .occ       (occ),
        .flush     (tx_end),
        .req_ready (mem_req_ready),
        .rsp_valid (mem_rsp_valid),
        .req_valid (mem_req_valid),
        .req_addr  (mem_req_addr),
        .rsp_keep  (rsp_keep)
    );

    // memory-facing stage of the pooled store
    pfx_fifo #(
        .WIDTH (32),
        .DEPTH (MEM_DEPTH)
    ) u_memq (
        .clk   (clk),
        .rst   (rst),
        .flush (tx_end),
        .push  (rsp_keep),
        .din   (mem_rsp_data),
        .pop   (mv),
        .dout  (mem_dout),
        .empty (mem_empty),
        .full  (mem_full),
        .count (mem_cnt)
    );

    // bus-facing stage; its head is what the master sees
    pfx_fifo #(
        .WIDTH (32),
        .DEPTH (BUS_DEPTH)
    ) u_busq (
        .clk   (clk),
        .rst   (rst),
        .flush (tx_end),
        .push  (mv),
        .din   (mem_dout),
        .pop   (xfer),
        .dout  (bus_dout),
        .empty (bus_empty),
        .full  (bus_full),
        .count (bus_cnt)
    );

    assign mv       = !mem_empty && !bus_full;
    assign occ      = CW'(bus_cnt) + CW'(mem_cnt);
    assign trdy_act = busy && !bus_empty;
    assign xfer     = trdy_act && !irdy_n;
    assign page_end = is_page_last(out_dw, PAGE_DW);
    assign stop_act = trdy_act && page_end;
    assign tx_end   = busy && ((xfer && (frame_n || page_end))
                               || (frame_n && irdy_n));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TGT_IDLE;
            frame_q <= 1'b1;
            out_dw  <= '0;
        end else begin
            frame_q <= frame_n;
            if (claim.hit) begin
                state  <= TGT_BUSY;
                out_dw <= claim.dw;
            end else begin
                if (tx_end) state <= TGT_IDLE;
                if (xfer) out_dw <= out_dw + 30'd1;
            end
        end
    end

    assign devsel_n = !busy;
    assign trdy_n   = !trdy_act;
    assign stop_n   = !stop_act;
    assign tgt_oe   = busy;
    assign ad_out   = bus_dout;
    assign ad_oe    = trdy_act;

    // R1: a decoded claim shows up on DEVSEL# one clock later
    p_claim_r1: assert property (@(posedge clk) disable iff (rst)
        claim.hit |=> !devsel_n);
    // R7: a fresh claim never offers data in its first clock
    p_first_wait_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> trdy_n);
    // R8: the store is empty after every transaction end
    p_flushed_r8: assert property (@(posedge clk) disable iff (rst)
        tx_end |=> (bus_empty && mem_empty));
    // R9: a disconnect always carries data with it
    p_stop_with_data_r9: assert property (@(posedge clk) disable iff (rst)
        !stop_n |-> (!trdy_n && ad_oe));

endmodule

// File: tb/sim_pci_rd_prefetch.sv
`timescale 1ns/1ps
module sim_pci_rd_prefetch;

    localparam logic [3:0] RD  = 4'b0110;
    localparam logic [3:0] WR  = 4'b0111;
    localparam int         LAT = 3;
    localparam int         CAPN = 26;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1, irdy_n = 1'b1, wr_empty = 1'b1;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        devsel_n, trdy_n, stop_n, tgt_oe, ad_oe;
    logic [31:0] ad_out, mem_req_addr, mem_rsp_data = '0;
    logic        mem_req_valid, mem_req_ready = 1'b1, mem_rsp_valid = 1'b0;

    always #4 clk = ~clk;

    pci_rd_prefetch u0 (
        .clk (clk), .rst (rst), .frame_n (frame_n), .irdy_n (irdy_n),
        .ad_in (ad_in), .cbe_n (cbe_n), .wr_empty (wr_empty),
        .devsel_n (devsel_n), .trdy_n (trdy_n), .stop_n (stop_n),
        .tgt_oe (tgt_oe), .ad_out (ad_out), .ad_oe (ad_oe),
        .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
        .mem_req_addr (mem_req_addr), .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data)
    );

    int  errs = 0, checks = 0, cyc = 0;
    int  tx_req = 0, tx_xfer = 0, cap_snap = 0, xfer_snap = 0;
    logic trdy_snap = 1'b1;
    logic [29:0] exp_fetch = '0;
    logic [19:0] tx_page = '0;
    bit  mem_stall = 0, finished = 0;
    logic [31:0] q_data[$];
    int          q_due[$];

    function automatic logic [31:0] mdat(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // behavioural memory and request monitor
    always @(negedge clk) begin
        #2;
        mem_req_ready = !(mem_stall && cyc[0]);
        if (!rst && mem_req_valid) begin
            chk(wr_empty, "R10 request while write pending", 32'(mem_req_valid), 32'h0);
            if (frame_n)
                chk(tx_req == tx_xfer, "R11 request after final phase",
                    32'(tx_req), 32'(tx_xfer));
        end
        if (!rst && mem_req_valid && mem_req_ready) begin
            chk(mem_req_addr == {exp_fetch, 2'b00}, "R6 request address",
                mem_req_addr, {exp_fetch, 2'b00});
            chk(mem_req_addr[31:12] == tx_page, "R9 request beyond page",
                32'(mem_req_addr[31:12]), 32'(tx_page));
            exp_fetch = exp_fetch + 30'd1;
            tx_req++;
            chk((tx_req - tx_xfer) <= CAPN, "R4 capacity exceeded",
                32'(tx_req - tx_xfer), 32'(CAPN));
            q_data.push_back(mdat(mem_req_addr));
            q_due.push_back(cyc + LAT);
        end
        if (q_due.size() > 0 && q_due[0] <= cyc) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = q_data.pop_front();
            void'(q_due.pop_front());
        end else begin
            mem_rsp_valid = 1'b0;
        end
    end

    // one read transaction as seen by a master
    task automatic rd(input logic [31:0] addr, input logic [3:0] cmd,
                      input int n, input int stall, input bit exp_claim,
                      input string tag, output int got);
        int left, wt;
        bit done;
        logic [29:0] cur;
        got = 0; left = n; wt = stall; done = 0; cur = addr[31:2];
        @(negedge clk); #1;
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
        tx_req = 0; tx_xfer = 0; exp_fetch = addr[31:2]; tx_page = addr[31:12];
        @(negedge clk); #1;
        ad_in = '0; cbe_n = 4'h0;
        chk(devsel_n == !exp_claim, tag, 32'(devsel_n), 32'(!exp_claim));
        chk(trdy_n == 1'b1, "R7 data in first clock", 32'(trdy_n), 32'h1);
        if (!exp_claim) begin
            frame_n = 1'b1;
            repeat (3) begin
                @(negedge clk); #1;
                chk(devsel_n && trdy_n && stop_n, tag,
                    {29'd0, devsel_n, trdy_n, stop_n}, 32'h7);
            end
            return;
        end
        irdy_n  = (wt > 0);
        frame_n = (wt == 0 && left == 1);
        for (int c = 0; c < 800 && !done; c++) begin
            if (!irdy_n && !trdy_n) begin
                chk(ad_oe && ad_out == mdat({cur, 2'b00}), tag,
                    ad_out, mdat({cur, 2'b00}));
                chk(stop_n == !(cur[9:0] == 10'h3FF), "R9 disconnect point",
                    32'(stop_n), 32'(!(cur[9:0] == 10'h3FF)));
                tx_xfer++; got++; cur = cur + 30'd1; left--;
                if (!stop_n || frame_n) done = 1;
            end
            @(negedge clk); #1;
            if (done) begin
                frame_n = 1'b1; irdy_n = 1'b1;
            end else if (wt > 0) begin
                wt--;
                if (wt == 0) begin
                    cap_snap = tx_req; xfer_snap = tx_xfer; trdy_snap = trdy_n;
                end
                irdy_n  = (wt > 0);
                frame_n = (wt == 0 && left == 1);
            end else begin
                irdy_n  = 1'b0;
                frame_n = (left == 1);
            end
        end
        chk(done, "R12 transaction did not finish", 32'(done), 32'h1);
        chk(devsel_n == 1'b1, "R12 release after last transfer", 32'(devsel_n), 32'h1);
        @(negedge clk);
    endtask

    initial begin
        int got;
        repeat (5) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(devsel_n && trdy_n && stop_n && !ad_oe && !tgt_oe, "R1 reset idle",
            {27'd0, devsel_n, trdy_n, stop_n, ad_oe, tgt_oe}, 32'h1C);
        chk(!mem_req_valid, "R10 reset no request", 32'(mem_req_valid), 32'h0);

        // plain burst
        rd(32'h0010_0040, RD, 8, 0, 1, "R1 claim", got);
        chk(got == 8, "R12 word count", 32'(got), 32'd8);

        // outside the window on both sides, and a non-read command
        rd(32'h0030_0000, RD, 4, 0, 0, "R2 above window", got);
        rd(32'h000F_FFFC, RD, 4, 0, 0, "R2 below window", got);
        rd(32'h0010_0200, WR, 4, 0, 0, "R3 write ignored", got);
        rd(32'h0010_0200, 4'b1100, 4, 0, 0, "R3 other read ignored", got);

        // capacity with the master stalled, then resumption
        rd(32'h0010_1000, RD, 40, 60, 1, "R6 data order", got);
        chk(cap_snap == CAPN, "R4 prefetch depth", 32'(cap_snap), 32'(CAPN));
        chk(trdy_snap == 1'b0, "R7 data offered while stalled", 32'(trdy_snap), 32'h0);
        chk(xfer_snap == 0, "R12 no transfer without IRDY", 32'(xfer_snap), 32'h0);
        chk(got == 40 && tx_req >= 40, "R5 fetch resumes", 32'(tx_req), 32'd40);

        // short read leaving a full store, then a fresh read
        rd(32'h0010_2000, RD, 3, 12, 1, "R6 data order", got);
        rd(32'h0010_2400, RD, 5, 0, 1, "R8 no stale data", got);
        chk(got == 5, "R8 word count", 32'(got), 32'd5);

        // end with requests still in flight on a slow memory
        mem_stall = 1;
        rd(32'h0010_3000, RD, 30, 0, 1, "R6 data order slow memory", got);
        rd(32'h0010_3800, RD, 6, 0, 1, "R8 no stale data after discard", got);
        mem_stall = 0;

        // page end disconnects
        rd(32'h0010_0FE8, RD, 20, 0, 1, "R6 data order", got);
        chk(got == 6, "R9 disconnect count", 32'(got), 32'd6);
        rd(32'h0010_1FC0, RD, 20, 30, 1, "R6 data order", got);
        chk(got == 16, "R9 disconnect count stalled", 32'(got), 32'd16);

        // posted-write gate
        wr_empty = 1'b0;
        fork
            rd(32'h0010_0800, RD, 4, 0, 1, "R10 data after gate", got);
            begin
                repeat (25) @(negedge clk);
                #1;
                chk(trdy_n == 1'b1, "R10 no data while gated", 32'(trdy_n), 32'h1);
                wr_empty = 1'b1;
            end
        join
        chk(got == 4, "R10 word count", 32'(got), 32'd4);

        // single-word read relies on the demand fetch
        rd(32'h0010_0100, RD, 1, 0, 1, "R11 single word", got);
        chk(got == 1, "R11 word count", 32'(got), 32'd1);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errs++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule